// File: doc/BRIEF.md
# Character-Mode Graphic LCD Controller

This block lets a page-organised monochrome graphic LCD act as a text display. A user pulses an enable with one byte and a flag saying whether the byte is a command or a character. A command byte goes straight to the panel as one instruction write. A character byte is turned into an 8x8 bitmap, and its eight column bytes are written into the current display page. The block keeps track of the column and page as it goes.

Glyphs come from a synchronous on-chip ROM. The ROM start address is the character code shifted left by three bits, and a counter steps through the eight bytes of the glyph. After reset the block first sends a fixed sequence of configuration instructions and then places the panel cursor at page 0, column 0. Only then does it accept user bytes. Every bus transfer is a 6800-style write whose register-select, read/write, data and enable timings are each counted in system clock cycles.

Top module: `lcd_char_ctrl`

## Requirements
- R1: While `rst_ni` is low, and from its release until the startup sequence is done, `busy_o` is high and `lcd_e_o` is low. After release the block issues these instruction writes (RS=0, RW=0), in this order: 0xA2, 0xA0, 0xC8, 0x2F, 0x26, 0x81, 0x1C, 0xAF, 0xB0, 0x10, 0x00.
- R2: While `en_i` stays low and the block is idle, no bus cycle occurs.
- R3: A byte accepted with `cmd_i`=1 produces exactly one instruction write (RS=0) carrying that byte. It does not move the page or column pointer.
- R4: A byte accepted with `cmd_i`=0 and a code below 0x80 produces eight display-data writes (RS=1). Write k (k=0..7) carries the code rotated left by k bit positions.
- R5: A character code of 0x80 or above produces eight display-data writes of 0x00.
- R6: Each character advances the column by 8. When fewer than 8 of the 132 columns remain, the last data write of that character is followed by three instruction writes: 0xB0 OR next page, then 0x10 OR column[7:4], then column[3:0]. Here column is 0. This happens after every 16 characters.
- R7: The wrap after the last visible page (page 7) goes back to page 0, so its page instruction is 0xB0.
- R8: In every write, RS, RW and DB are stable for at least SETUP_CYC cycles before `lcd_e_o` rises. `lcd_e_o` stays high for exactly PULSE_CYC cycles. The bus stays unchanged for at least HOLD_CYC cycles after `lcd_e_o` falls. `lcd_rw_o` is always 0.
- R9: `busy_o` is high from the cycle after a byte is accepted until that byte's last write has finished. Enable pulses that arrive while `busy_o` is high produce no bus cycles.
- R10: Asserting `rst_ni` low in the middle of a transfer abandons it. The block repeats the R1 sequence and clears the pointers to page 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transfer request, sampled when idle |
| cmd_i | input | 1 | 1 = command byte, 0 = character code |
| byte_i | input | 8 | Command or character byte |
| busy_o | output | 1 | Startup or transfer in progress |
| lcd_rs_o | output | 1 | Register select, 1 = display data |
| lcd_rw_o | output | 1 | Read/write, always write (0) |
| lcd_e_o | output | 1 | Enable strobe |
| lcd_db_o | output | 8 | Parallel data bus |

## Verification
The bench targets four weak spots:
- **Column wrap.** It sends exactly 16 characters after reset, with a command mixed in. A pointer that is off by one, or that a command disturbs, places the three address writes after the wrong character, and the scoreboard reports a mismatch there.
- **Page wrap.** It runs the full 128 characters to reach the wrap from page 7 back to page 0. A design that keeps counting pages would send 0xB8 instead of 0xB0.
- **Enables while busy.** It pulses the enable during a transfer. A design that accepted those pulses would emit extra writes, which show up as unexpected items against an empty queue.
- **Reset mid-transfer.** It resets the block in the middle of a glyph. A design that kept its old pointers would wrap at the wrong place.

In addition, the bus monitor measures setup, pulse and hold in cycles on every single write.

// File: rtl/lcd_char_pkg.sv
package lcd_char_pkg;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_CMD, ST_FETCH, ST_GLYPH, ST_ADDR
  } ctl_state_e;

  typedef enum logic [1:0] {
    BW_IDLE, BW_SETUP, BW_PULSE, BW_HOLD
  } bw_state_e;

  localparam int INIT_LEN  = 8;
  localparam int GLYPH_H   = 8;
  localparam int ROW_BITS  = $clog2(GLYPH_H);

  // panel configuration: bias, segment dir, common dir, power, regulator, volume pair, display on
  function automatic logic [7:0] init_word(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'hA2;
      3'd1:    return 8'hA0;
      3'd2:    return 8'hC8;
      3'd3:    return 8'h2F;
      3'd4:    return 8'h26;
      3'd5:    return 8'h81;
      3'd6:    return 8'h1C;
      default: return 8'hAF;
    endcase
  endfunction

  // computed placeholder font: row k is the code rotated left by k
  function automatic logic [7:0] glyph_byte(input logic [7:0] code, input logic [2:0] k);
    logic [15:0] dbl;
    dbl = {code, code} << k;
    return dbl[15:8];
  endfunction

endpackage

// File: rtl/glyph_rom.sv
module glyph_rom
  import lcd_char_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                         clk_i,
  input  logic [CODE_W+ROW_BITS-1:0]   addr_i,
  output logic [7:0]                   q_o
);
  localparam int ADDR_W = CODE_W + ROW_BITS;

  logic [7:0] q_q;

  // codes with the top bit set are outside the font and read as blank
  always_ff @(posedge clk_i) begin
    if (addr_i[ADDR_W-1]) q_q <= 8'h00;
    else q_q <= glyph_byte(8'(addr_i[ADDR_W-1:ROW_BITS]), addr_i[ROW_BITS-1:0]);
  end

  assign q_o = q_q;
endmodule

// File: rtl/bus_writer.sv
module bus_writer
  import lcd_char_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rs_i,
  input  logic [7:0] db_i,
  output logic       ready_o,
  output logic       done_o,
  output logic       e_o,
  output logic       rs_o,
  output logic [7:0] db_o
);
  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  bw_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             e_q, rs_q, done_q;
  logic [7:0]       db_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BW_IDLE;
      cnt_q  <= '0;
      e_q    <= 1'b0;
      rs_q   <= 1'b0;
      db_q   <= 8'h00;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        BW_IDLE: if (start_i) begin
          rs_q  <= rs_i;
          db_q  <= db_i;
          cnt_q <= '0;
          st_q  <= BW_SETUP;
        end
        BW_SETUP: if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
          cnt_q <= '0;
          e_q   <= 1'b1;
          st_q  <= BW_PULSE;
        end else cnt_q <= cnt_q + 1'b1;
        BW_PULSE: if (cnt_q == CNT_W'(PULSE_CYC - 1)) begin
          cnt_q <= '0;
          e_q   <= 1'b0;
          st_q  <= BW_HOLD;
        end else cnt_q <= cnt_q + 1'b1;
        default: if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          st_q   <= BW_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  assign ready_o = (st_q == BW_IDLE);
  assign done_o  = done_q;
  assign e_o     = e_q;
  assign rs_o    = rs_q;
  assign db_o    = db_q;

  assert_bus_stable_in_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_q |-> ($stable(db_q) && $stable(rs_q)));

  assert_no_strobe_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !e_q);
endmodule

// File: rtl/cursor_track.sv
module cursor_track #(
  parameter int COLS    = 132,
  parameter int PAGES   = 8,
  parameter int GLYPH_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      adv_i,
  output logic [$clog2(COLS)-1:0]   col_o,
  output logic [$clog2(PAGES)-1:0]  page_o,
  output logic                      wrap_o
);
  localparam int COL_W  = $clog2(COLS);
  localparam int PAGE_W = $clog2(PAGES);

  logic [COL_W-1:0]  col_q;
  logic [PAGE_W-1:0] page_q;

  // the next advance leaves fewer than GLYPH_W columns
  assign wrap_o = (int'(col_q) + 2 * GLYPH_W) > COLS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      page_q <= '0;
    end else if (adv_i) begin
      if (wrap_o) begin
        col_q  <= '0;
        page_q <= (page_q == PAGE_W'(PAGES - 1)) ? '0 : page_q + 1'b1;
      end else begin
        col_q <= col_q + COL_W'(GLYPH_W);
      end
    end
  end

  assign col_o  = col_q;
  assign page_o = page_q;

  assert_col_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(col_q) + GLYPH_W) <= COLS);

  assert_col_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_o) |=> (int'(col_q) == int'($past(col_q)) + GLYPH_W));

  assert_page_return_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_o && page_q == PAGE_W'(PAGES - 1)) |=> (page_q == '0 && col_q == '0));
endmodule

// File: rtl/lcd_char_ctrl.sv
module lcd_char_ctrl
  import lcd_char_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int COLS      = 132,
  parameter int PAGES     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       cmd_i,
  input  logic [7:0] byte_i,
  output logic       busy_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_db_o
);
  localparam int COL_W  = $clog2(COLS);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int PTR_W  = 8 + ROW_BITS;

  ctl_state_e        st_q;
  logic              issued_q;
  logic [2:0]        init_idx_q;
  logic [1:0]        addr_idx_q;
  logic [7:0]        code_q;
  logic [PTR_W-1:0]  ptr_q;

  logic              bw_start, bw_rs, bw_ready, bw_done;
  logic [7:0]        bw_db, rom_q, col8, page8;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic              wrap, adv, last_row, issuing;

  assign last_row = (ptr_q[ROW_BITS-1:0] == ROW_BITS'(GLYPH_H - 1));
  assign adv      = (st_q == ST_GLYPH) && bw_done && last_row;
  assign col8     = 8'(col);
  assign page8    = 8'(page);
  assign issuing  = (st_q == ST_INIT) || (st_q == ST_CMD) ||
                    (st_q == ST_GLYPH) || (st_q == ST_ADDR);
  assign bw_start = issuing && bw_ready && !issued_q;
  assign bw_rs    = (st_q == ST_GLYPH);

  always_comb begin
    case (st_q)
      ST_INIT:  bw_db = init_word(init_idx_q);
      ST_CMD:   bw_db = code_q;
      ST_GLYPH: bw_db = rom_q;
      ST_ADDR: begin
        case (addr_idx_q)
          2'd0:    bw_db = 8'hB0 | page8;
          2'd1:    bw_db = 8'h10 | {4'h0, col8[7:4]};
          default: bw_db = {4'h0, col8[3:0]};
        endcase
      end
      default:  bw_db = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_INIT;
      issued_q   <= 1'b0;
      init_idx_q <= '0;
      addr_idx_q <= '0;
      code_q     <= 8'h00;
      ptr_q      <= '0;
    end else begin
      if (bw_start) issued_q <= 1'b1;
      else if (bw_done) issued_q <= 1'b0;
      case (st_q)
        ST_INIT: if (bw_done) begin
          if (init_idx_q == 3'(INIT_LEN - 1)) begin
            addr_idx_q <= '0;
            st_q       <= ST_ADDR;
          end else init_idx_q <= init_idx_q + 1'b1;
        end
        ST_IDLE: if (en_i) begin
          code_q <= byte_i;
          if (cmd_i) st_q <= ST_CMD;
          else begin
            ptr_q <= {byte_i, {ROW_BITS{1'b0}}};
            st_q  <= ST_FETCH;
          end
        end
        ST_CMD: if (bw_done) st_q <= ST_IDLE;
        ST_FETCH: st_q <= ST_GLYPH;
        ST_GLYPH: if (bw_done) begin
          if (last_row) begin
            addr_idx_q <= '0;
            st_q       <= wrap ? ST_ADDR : ST_IDLE;
          end else begin
            ptr_q <= ptr_q + 1'b1;
            st_q  <= ST_FETCH;
          end
        end
        ST_ADDR: if (bw_done) begin
          if (addr_idx_q == 2'd2) st_q <= ST_IDLE;
          else addr_idx_q <= addr_idx_q + 1'b1;
        end
        default: st_q <= ST_INIT;
      endcase
    end
  end

  glyph_rom #(.CODE_W(8)) u_rom (
    .clk_i  (clk_i),
    .addr_i (ptr_q),
    .q_o    (rom_q)
  );

  bus_writer #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bw_start),
    .rs_i    (bw_rs),
    .db_i    (bw_db),
    .ready_o (bw_ready),
    .done_o  (bw_done),
    .e_o     (lcd_e_o),
    .rs_o    (lcd_rs_o),
    .db_o    (lcd_db_o)
  );

  cursor_track #(
    .COLS    (COLS),
    .PAGES   (PAGES),
    .GLYPH_W (GLYPH_H)
  ) u_cursor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .col_o  (col),
    .page_o (page),
    .wrap_o (wrap)
  );

  assign busy_o   = (st_q != ST_IDLE);
  assign lcd_rw_o = 1'b0;

  assert_quiet_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !lcd_e_o);

  assert_code_held_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(code_q));

  assert_data_only_from_glyph_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && lcd_rs_o) |-> (st_q == ST_GLYPH));
endmodule

// File: tb/lcd_char_ctrl_test.sv
module lcd_char_ctrl_test;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cmd = 1'b0;
  logic [7:0] din = 8'h00;
  logic       busy, lcd_rs, lcd_rw, lcd_e;
  logic [7:0] lcd_db;

  int checks = 0;
  int errors = 0;
  int writes = 0;
  int col_m  = 0;
  int page_m = 0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  lcd_char_ctrl #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cmd_i(cmd), .byte_i(din),
    .busy_o(busy), .lcd_rs_o(lcd_rs), .lcd_rw_o(lcd_rw), .lcd_e_o(lcd_e), .lcd_db_o(lcd_db)
  );

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [7:0] rotl(input logic [7:0] c, input int k);
    if (k == 0) return c;
    return (c << k) | (c >> (8 - k));
  endfunction

  task automatic push(input logic rs, input logic [7:0] b);
    exp_q.push_back({rs, b});
  endtask

  task automatic push_init();
    logic [7:0] seq [11] = '{8'hA2, 8'hA0, 8'hC8, 8'h2F, 8'h26, 8'h81, 8'h1C, 8'hAF,
                             8'hB0, 8'h10, 8'h00};
    foreach (seq[i]) push(1'b0, seq[i]);
  endtask

  // model of R4..R7
  task automatic push_glyph(input logic [7:0] c);
    for (int k = 0; k < 8; k++) push(1'b1, (c >= 8'h80) ? 8'h00 : rotl(c, k));
    col_m += 8;
    if (132 - col_m < 8) begin
      col_m  = 0;
      page_m = (page_m + 1) % 8;
      push(1'b0, 8'hB0 | 8'(page_m));
      push(1'b0, 8'h10 | 8'(col_m >> 4));
      push(1'b0, 8'(col_m & 15));
    end
  endtask

  task automatic send(input logic is_cmd, input logic [7:0] b);
    while (busy) @(negedge clk);
    if (is_cmd) push(1'b0, b); else push_glyph(b);
    en = 1'b1; cmd = is_cmd; din = b;
    @(negedge clk);
    en = 1'b0;
    check("R9 busy after accept", int'(busy), 1);
  endtask

  task automatic drain();
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: bus timing (R8) and scoreboard compare
  logic [8:0] prev_bus;
  logic       e_prev = 1'b0, fell_seen = 1'b0;
  int hi_cnt = 0, stable_cnt = 0, since_fall = 0;

  always @(negedge clk) begin
    logic [8:0] cur;
    logic [8:0] exp_v;
    cur = {lcd_rs, lcd_db};
    if (!rst_n) begin
      e_prev = 1'b0; fell_seen = 1'b0; hi_cnt = 0; stable_cnt = 0; since_fall = 0;
    end else begin
      if (cur == prev_bus) stable_cnt++;
      else begin
        if (fell_seen) check("R8 hold cycles", (since_fall >= HOLD) ? 1 : 0, 1);
        stable_cnt = 1;
        fell_seen  = 1'b0;
      end
      if (lcd_e && !e_prev) begin
        writes++;
        fell_seen = 1'b0;
        check("R8 setup cycles", (stable_cnt > SETUP) ? 1 : 0, 1);
        check("R8 rw low", int'(lcd_rw), 0);
        if (exp_q.size() == 0) check("R9 unexpected write", int'(cur), 'h1FF);
        else begin
          exp_v = exp_q.pop_front();
          check("R1/R3/R4/R5/R6/R7 bus word", int'(cur), int'(exp_v));
        end
      end
      if (lcd_e) hi_cnt++;
      if (!lcd_e && e_prev) begin
        check("R8 pulse width", hi_cnt, PULSE);
        hi_cnt = 0;
        fell_seen = 1'b1;
        since_fall = 1;
      end else if (fell_seen) since_fall++;
      e_prev = lcd_e;
    end
    prev_bus = cur;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    // R1: reset state and startup sequence
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 1);
    check("R1 e low in reset", int'(lcd_e), 0);
    push_init();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 1);
    drain();
    check("R1 sequence consumed", exp_q.size(), 0);

    // R2: idle with enable low
    w0 = writes;
    repeat (60) @(negedge clk);
    check("R2 no writes when idle", writes - w0, 0);

    // R3: command passthrough
    send(1'b1, 8'hAE);
    drain();

    // R4/R5: glyph data
    send(1'b0, 8'h41);
    send(1'b0, 8'h20);
    send(1'b0, 8'h7F);
    send(1'b0, 8'h85);
    send(1'b0, 8'hFF);
    drain();

    // R9: enables while busy ignored
    w0 = writes;
    send(1'b0, 8'h5A);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); en = 1'b1; cmd = 1'b1; din = 8'h33;
      @(negedge clk); en = 1'b0;
    end
    drain();
    check("R9 only one transfer", writes - w0, 8);

    // R10: reset mid transfer
    send(1'b0, 8'h42);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    col_m = 0; page_m = 0;
    repeat (3) @(negedge clk);
    push_init();
    rst_n = 1'b1;
    drain();
    check("R10 restart consumed", exp_q.size(), 0);

    // R6 (and R3 pointer untouched): 16 glyphs with a command inside
    for (int i = 0; i < 16; i++) begin
      send(1'b0, 8'(8'h30 + i));
      if (i == 4) send(1'b1, 8'hA6);
    end
    drain();
    check("R6 first wrap to page 1", page_m, 1);

    // R7: remaining pages back to page 0
    for (int i = 0; i < 112; i++) send(1'b0, 8'((i * 37) & 8'hFF));
    drain();
    check("R7 page back to zero", page_m, 0);
    check("R7 queue empty", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule